// File: doc/BRIEF.md
# Stuck-Dominant Fault Guard

This block sits between a CAN protocol controller and the bus transceiver logic. It keeps a single stuck-low line from taking over the bus or the controller. Two watchdogs share one timeout, given in clock cycles. In run mode the first watchdog times how long the transmit-data input stays low. If the low lasts past the timeout, the driver enable is withdrawn. The other node traffic on the bus still reaches the receive output.

In quiet (low-power) mode the second watchdog times how long the bus stays dominant. If the dominant lasts past the timeout, the receive output is pinned recessive (high) so that the controller can stay asleep. This fault also holds off wake-up. It stays latched until the bus is seen recessive again, whatever the mode does in between. Each watchdog restarts whenever its monitored line returns to the inactive level, and also in the cycle in which the mode input changes.

Top module: `pdom_guard`

## Requirements
- R1: While reset is asserted and just after its release, both fault flags and `wake_inhibit_o` are 0. With `mode_stby_i`=0, `drv_en_o` is 1.
- R2: `drv_en_o` is 0 whenever `mode_stby_i`=1 (quiet mode). In run mode it is 1 unless the transmit fault is set.
- R3: In run mode (`mode_stby_i`=0), `txd_i`=0 sampled on TIMEOUT_CYC consecutive rising edges does not set `tx_fault_o`. A further low sample sets it, which is edge TIMEOUT_CYC+1, and `drv_en_o` falls to 0 at the same time.
- R4: A set `tx_fault_o` is cleared by the first rising edge that samples `txd_i`=1, and `drv_en_o` returns to 1 in run mode. Until that edge the fault holds.
- R5: While `tx_fault_o` is set in run mode, `rxd_o` follows the bus: it is 0 when `bus_dom_i`=1 (dominant) and 1 when `bus_dom_i`=0.
- R6: In quiet mode, `bus_dom_i`=1 sampled on TIMEOUT_CYC+1 consecutive edges sets `bus_fault_o`. TIMEOUT_CYC samples do not set it. While the fault is set in quiet mode, `rxd_o` is 1 and `rxd_force_o` is 1.
- R7: A set `bus_fault_o` holds while `bus_dom_i`=1, including across a change to run mode. It is cleared by the first edge that samples `bus_dom_i`=0.
- R8: `wake_inhibit_o` is 1 exactly while the bus fault is latched.
- R9: Each watchdog restarts in the cycle in which `mode_stby_i` differs from its value at the previous edge. Entering run mode with `txd_i` already low therefore needs TIMEOUT_CYC+2 edges to set the transmit fault.
- R10: A single inactive sample (`txd_i`=1) restarts the transmit watchdog. A new low span then needs the full TIMEOUT_CYC+1 samples again.
- R11: With no bus fault, `rxd_o` is the inverse of `bus_dom_i` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_stby_i | input | 1 | 0 = run mode, 1 = quiet mode |
| txd_i | input | 1 | Transmit data from controller, 0 = dominant |
| bus_dom_i | input | 1 | Bus level from receiver, 1 = dominant |
| drv_en_o | output | 1 | Bus driver enable |
| rxd_o | output | 1 | Receive data to controller, 0 = dominant |
| rxd_force_o | output | 1 | Receive output pinned recessive by bus fault |
| tx_fault_o | output | 1 | Transmit stuck-low fault |
| bus_fault_o | output | 1 | Bus stuck-dominant fault (latched) |
| wake_inhibit_o | output | 1 | Wake-up blocked while bus fault latched |

## Verification
The bench targets the exact timeout boundary on both watchdogs: TIMEOUT_CYC low samples must not fault, and one more must. An off-by-one comparator would fault a cycle early or late. A single-cycle high glitch in the middle of a low span must restart the count. A counter that only pauses would fault too soon. Switching into run mode with the transmit line already low must lose one cycle to the restart. The bus fault must survive a change to run mode and release only on a recessive sample, so a design that cleared it on the mode change, or that pinned the receive line in run mode, is caught. Throughout the transmit fault, the bench also checks that bus data still reaches the receive output.

// File: rtl/pdom_pkg.sv
package pdom_pkg;

  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_QUIET = 1'b1
  } pdom_mode_e;

  // watchdog channel indices
  localparam int CH_TX  = 0;
  localparam int CH_BUS = 1;
  localparam int N_CH   = 2;

  // next value of a saturating consecutive-sample counter
  function automatic int unsigned wd_next(input int unsigned cnt,
                                          input logic active,
                                          input logic restart,
                                          input int unsigned limit);
    if (!active || restart) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

  // a fault is raised when the counter already sits at the limit
  // and the line is still active without a restart
  function automatic logic wd_expire(input int unsigned cnt,
                                     input logic active,
                                     input logic restart,
                                     input int unsigned limit);
    return active && !restart && (cnt == limit);
  endfunction

endpackage

// File: rtl/pdom_mode_trk.sv
module pdom_mode_trk
  import pdom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_stby_i,
  output pdom_mode_e mode_o,
  output logic       changed_o
);

  pdom_mode_e mode_q;
  pdom_mode_e mode_now;

  assign mode_now = mode_stby_i ? MODE_QUIET : MODE_RUN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_now;
  end

  assign mode_o    = mode_now;
  assign changed_o = (mode_now != mode_q);

endmodule

// File: rtl/pdom_wdog.sv
module pdom_wdog
  import pdom_pkg::*;
#(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic restart_i,
  input  logic release_i,
  output logic expire_o,
  output logic fault_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d;
  logic          expire;

  always_comb begin
    cnt_d  = CW'(wd_next(int'(cnt_q), active_i, restart_i, LIMIT));
    expire = wd_expire(int'(cnt_q), active_i, restart_i, LIMIT);
    if (expire)         fault_d = 1'b1;
    else if (release_i) fault_d = 1'b0;
    else                fault_d = fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign expire_o = expire;
  assign fault_o  = fault_q;

endmodule

// File: rtl/pdom_guard.sv
module pdom_guard
  import pdom_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_stby_i,
  input  logic txd_i,
  input  logic bus_dom_i,
  output logic drv_en_o,
  output logic rxd_o,
  output logic rxd_force_o,
  output logic tx_fault_o,
  output logic bus_fault_o,
  output logic wake_inhibit_o
);

  pdom_mode_e mode;
  logic       mode_chg;

  logic [N_CH-1:0] ch_active;
  logic [N_CH-1:0] ch_release;
  logic [N_CH-1:0] ch_expire;
  logic [N_CH-1:0] ch_fault;

  pdom_mode_trk u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_stby_i(mode_stby_i),
    .mode_o     (mode),
    .changed_o  (mode_chg)
  );

  // channel qualification: transmit line low in run mode,
  // bus dominant in quiet mode
  assign ch_active[CH_TX]   = (mode == MODE_RUN)   && !txd_i;
  assign ch_active[CH_BUS]  = (mode == MODE_QUIET) && bus_dom_i;
  assign ch_release[CH_TX]  = txd_i;
  assign ch_release[CH_BUS] = !bus_dom_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_wd
    pdom_wdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (ch_active[g]),
      .restart_i(mode_chg),
      .release_i(ch_release[g]),
      .expire_o (ch_expire[g]),
      .fault_o  (ch_fault[g])
    );
  end

  assign tx_fault_o     = ch_fault[CH_TX];
  assign bus_fault_o    = ch_fault[CH_BUS];
  assign wake_inhibit_o = ch_fault[CH_BUS];
  assign drv_en_o       = (mode == MODE_RUN) && !ch_fault[CH_TX];
  assign rxd_force_o    = (mode == MODE_QUIET) && ch_fault[CH_BUS];
  assign rxd_o          = rxd_force_o ? 1'b1 : !bus_dom_i;

endmodule

module pdom_guard_chk #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic mode_stby_i,
  input logic txd_i,
  input logic bus_dom_i,
  input logic drv_en_o,
  input logic rxd_o,
  input logic rxd_force_o,
  input logic tx_fault_o,
  input logic bus_fault_o,
  input logic wake_inhibit_o
);

  // independent run-length tracker for the transmit low span
  int unsigned tx_run_q;
  logic        mode_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run_q    <= 0;
      mode_prev_q <= 1'b0;
    end else begin
      mode_prev_q <= mode_stby_i;
      if (mode_stby_i || txd_i || (mode_stby_i != mode_prev_q)) tx_run_q <= 0;
      else if (tx_run_q <= TIMEOUT_CYC) tx_run_q <= tx_run_q + 1;
    end
  end

  AST_TX_RISE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_fault_o) |-> $past(tx_run_q) >= TIMEOUT_CYC); // R3

  AST_TX_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_fault_o) |-> $past(!txd_i) && $past(!mode_stby_i)); // R3

  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fault_o && txd_i |=> !tx_fault_o); // R4

  AST_TX_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fault_o |-> !drv_en_o); // R2

  AST_TX_RX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fault_o && !mode_stby_i |-> rxd_o == !bus_dom_i); // R5

  AST_BUS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault_o && mode_stby_i |-> rxd_o); // R6

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault_o && bus_dom_i |=> bus_fault_o); // R7

  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault_o && !bus_dom_i |=> !bus_fault_o); // R7

  AST_WAKE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_inhibit_o) |-> $past(mode_stby_i) && $past(bus_dom_i)); // R8

  AST_STBY_NO_DRV: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stby_i |-> !drv_en_o); // R2

endmodule

bind pdom_guard pdom_guard_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (.*);

// File: tb/pdom_guard_tb.sv
module pdom_guard_tb_top;

  localparam int CLK_P = 10;
  localparam int TO    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_stby_i = 1'b0;
  logic txd_i = 1'b1;
  logic bus_dom_i = 1'b0;
  logic drv_en_o, rxd_o, rxd_force_o, tx_fault_o, bus_fault_o, wake_inhibit_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pdom_guard #(.TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_stby_i(mode_stby_i), .txd_i(txd_i),
    .bus_dom_i(bus_dom_i), .drv_en_o(drv_en_o), .rxd_o(rxd_o),
    .rxd_force_o(rxd_force_o), .tx_fault_o(tx_fault_o),
    .bus_fault_o(bus_fault_o), .wake_inhibit_o(wake_inhibit_o)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic t_reset();
    chk("R1", "tx_fault in reset", tx_fault_o, 1'b0);
    chk("R1", "bus_fault in reset", bus_fault_o, 1'b0);
    step(2);
    rst_n = 1'b1;
    step(2);
    chk("R1", "drv_en after reset", drv_en_o, 1'b1);
    chk("R1", "wake_inhibit after reset", wake_inhibit_o, 1'b0);
    chk("R11", "rxd recessive bus", rxd_o, 1'b1);
  endtask

  task automatic t_tx_boundary();
    txd_i = 1'b0;
    step(TO);
    chk("R3", "no fault at limit", tx_fault_o, 1'b0);
    chk("R2", "drv_en before fault", drv_en_o, 1'b1);
    txd_i = 1'b1;
    step(2);
    txd_i = 1'b0;
    step(TO + 1);
    chk("R3", "fault past limit", tx_fault_o, 1'b1);
    chk("R3", "drv_en off", drv_en_o, 1'b0);
    bus_dom_i = 1'b1;
    step(1);
    chk("R5", "rxd dominant during fault", rxd_o, 1'b0);
    bus_dom_i = 1'b0;
    step(4);
    chk("R5", "rxd recessive during fault", rxd_o, 1'b1);
    chk("R4", "fault held while low", tx_fault_o, 1'b1);
    txd_i = 1'b1;
    step(1);
    chk("R4", "fault cleared", tx_fault_o, 1'b0);
    chk("R4", "drv_en back", drv_en_o, 1'b1);
  endtask

  task automatic t_glitch();
    txd_i = 1'b0;
    step(TO - 2);
    txd_i = 1'b1;
    step(1);
    txd_i = 1'b0;
    step(TO);
    chk("R10", "no fault after restart", tx_fault_o, 1'b0);
    step(1);
    chk("R10", "fault on full span", tx_fault_o, 1'b1);
    txd_i = 1'b1;
    step(2);
  endtask

  task automatic t_mode_restart();
    mode_stby_i = 1'b1;
    txd_i = 1'b0;
    step(3);
    chk("R2", "drv_en off in quiet", drv_en_o, 1'b0);
    chk("R3", "no tx fault in quiet", tx_fault_o, 1'b0);
    mode_stby_i = 1'b0;
    step(TO + 1);
    chk("R9", "no fault one after entry", tx_fault_o, 1'b0);
    step(1);
    chk("R9", "fault after restart window", tx_fault_o, 1'b1);
    txd_i = 1'b1;
    step(2);
  endtask

  task automatic t_bus();
    mode_stby_i = 1'b1;
    step(2);
    bus_dom_i = 1'b1;
    step(TO);
    chk("R6", "no bus fault at limit", bus_fault_o, 1'b0);
    chk("R11", "rxd follows dominant", rxd_o, 1'b0);
    step(1);
    chk("R6", "bus fault past limit", bus_fault_o, 1'b1);
    chk("R6", "rxd forced high", rxd_o, 1'b1);
    chk("R6", "rxd_force set", rxd_force_o, 1'b1);
    chk("R8", "wake inhibited", wake_inhibit_o, 1'b1);
    step(5);
    chk("R7", "bus fault held", bus_fault_o, 1'b1);
    mode_stby_i = 1'b0;
    step(3);
    chk("R7", "held across mode change", bus_fault_o, 1'b1);
    chk("R7", "rxd not forced in run", rxd_o, 1'b0);
    bus_dom_i = 1'b0;
    step(1);
    chk("R7", "bus fault released", bus_fault_o, 1'b0);
    chk("R8", "wake inhibit released", wake_inhibit_o, 1'b0);
    chk("R11", "rxd recessive after release", rxd_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_tx_boundary();
    t_glitch();
    t_mode_restart();
    t_bus();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

endmodule